// File: doc/BRIEF.md
# Pipelined Synchronous Burst Memory

This block is a single-port, word-organised memory with a 32-bit word split into four 8-bit byte lanes. Every control, address and write-data input is captured on the rising clock edge. Two address strobes can start an access. The processor-side strobe always starts a read and is qualified by the primary chip enable. The controller-side strobe starts either a read or a write, depending on the write controls. Once an access has started, the advance input either steps to the next address of a four-beat burst or holds the current address as a wait cycle. Either kind of cycle may read or write.

Read data comes out of an output register one clock after its address is captured. A separate output-valid flag replaces a tri-state driver. That flag is cleared at once by a high output enable or by the sleep input. It is also cleared for the cycle that follows any write edge, and from the second edge after a deselect. The burst order is chosen by a static mode input: linear (wrapping increment) or interleaved (XOR).

Top module: `burst_sram`

## Requirements
- R1: After reset, `dout_en` is 0 and no burst is active, so strobe-free edges perform no access.
- R2: An edge with `sp_n`=0, `ce_n`=0, `ce2`=1 and `ce2_n`=0 captures `addr` and starts a read, even when the write controls request a write. The word appears on `dout` with `dout_en`=1 after the next edge.
- R3: An edge with `sc_n`=0 and the chip selected (and the processor start not taken) captures `addr`. It starts a write when the write request is true and a read otherwise. The write request is true when `gw_n`=0, or when `bwe_n`=0 and at least one bit of `bw_n` is 0.
- R4: When `gw_n`=0, a write updates all four lanes. Otherwise, with `bwe_n`=0, each lane n for which `bw_n[n]`=0 takes `din[8n+7:8n]`, and the other lanes keep their contents.
- R5: On an edge with both strobes high during an active burst, `adv_n`=0 moves to the next beat k (k counts modulo 4 from the start beat 0). The low two address bits become start+k mod 4 when `linear_mode`=1, and start XOR k when `linear_mode`=0. The upper bits stay those of the start address.
- R6: On an edge with both strobes high during an active burst, `adv_n`=1 repeats the current address as a wait cycle. A write on the wait cycle right after a processor-strobe start stores to the start address.
- R7: While `ce_n`=1, `sp_n` has no effect: with `sc_n`=1 the burst continues, and with `sc_n`=0 the device is deselected. A deselect also happens when either strobe starts an access while `ce2`=0 or `ce2_n`=1.
- R8: After a deselecting edge, a word read on the previous edge is still shown for one cycle. `dout_en` is 0 from the second edge on, and strobe-free edges then make no access.
- R9: `oe_n`=1 forces `dout_en` to 0 without waiting for a clock edge.
- R10: `dout_en` is 0 for the whole cycle that follows any edge that performed a write.
- R11: While `sleep`=1, `dout_en` is 0, every edge is ignored, and memory contents and burst position are kept. The burst resumes where it stopped once `sleep` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | External word address |
| ce_n | input | 1 | Primary chip enable, active low; also qualifies `sp_n` |
| ce2 | input | 1 | Expansion chip enable, active high |
| ce2_n | input | 1 | Expansion chip enable, active low |
| sp_n | input | 1 | Processor-side address strobe, active low |
| sc_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low; high means wait cycle |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write gate, active low |
| bw_n | input | 4 | Per-lane byte enables, active low |
| linear_mode | input | 1 | Burst order: 1 linear, 0 interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous standby: freezes the block |
| din | input | 32 | Write data |
| dout | output | 32 | Read data from the output register |
| dout_en | output | 1 | High when `dout` would be driven |

## Verification
Two functions can meet in one cycle. The output register loads the word fetched for a read on the edge where a new write, to the same word or another, is accepted, and a deselect can land on the edge that follows a read. Directed sequences build both cases: a read of a word followed at once by a write to that word, then a read-back; and a read followed by a deselect. Constrained-random traffic then mixes strobes, advance, sleep and output enable freely. A bench model predicts `dout_en` and `dout` at every falling edge. It checks that the write cycle hides the stale word, that the later read returns the new data, and that the deselect removes the output exactly one cycle after the last word is shown.

// File: rtl/sbsr_pkg.sv
package sbsr_pkg;

  localparam int NUM_LANES = 4;
  localparam int BURST_W   = 2;

  typedef enum logic [2:0] {
    OP_IDLE,
    OP_DESEL,
    OP_START,
    OP_STEP,
    OP_WAIT
  } op_e;

  // True when the write controls ask for any write at all.
  function automatic logic write_requested(input logic gw_n,
                                           input logic bwe_n,
                                           input logic [NUM_LANES-1:0] bw_n);
    return !gw_n || (!bwe_n && !(&bw_n));
  endfunction

  // Per-lane write enables: global write overrides the byte enables.
  function automatic logic [NUM_LANES-1:0] lane_enables(input logic gw_n,
                                                        input logic bwe_n,
                                                        input logic [NUM_LANES-1:0] bw_n);
    if (!gw_n) return '1;
    if (!bwe_n) return ~bw_n;
    return '0;
  endfunction

  // Low address bits of beat number `beat` for a burst starting at `first`.
  function automatic logic [BURST_W-1:0] burst_offset(input logic [BURST_W-1:0] first,
                                                      input logic [BURST_W-1:0] beat,
                                                      input logic linear);
    return linear ? (first + beat) : (first ^ beat);
  endfunction

endpackage

// File: rtl/sbsr_decode.sv
module sbsr_decode
  import sbsr_pkg::*;
(
  input  logic                 ce_n,
  input  logic                 ce2,
  input  logic                 ce2_n,
  input  logic                 sp_n,
  input  logic                 sc_n,
  input  logic                 adv_n,
  input  logic                 gw_n,
  input  logic                 bwe_n,
  input  logic [NUM_LANES-1:0] bw_n,
  input  logic                 burst_act,
  input  logic                 sleep,
  output op_e                  op,
  output logic                 acc_write
);

  logic selected;
  logic proc_start;
  logic wr_req;

  assign selected   = !ce_n && ce2 && !ce2_n;
  assign proc_start = !sp_n && !ce_n;
  assign wr_req     = write_requested(gw_n, bwe_n, bw_n);

  always_comb begin
    op        = OP_IDLE;
    acc_write = 1'b0;
    if (sleep) begin
      op        = OP_IDLE;
      acc_write = 1'b0;
    end else if (proc_start) begin
      // processor strobe: always a read
      op        = selected ? OP_START : OP_DESEL;
      acc_write = 1'b0;
    end else if (!sc_n) begin
      op        = selected ? OP_START : OP_DESEL;
      acc_write = selected && wr_req;
    end else if (burst_act) begin
      op        = adv_n ? OP_WAIT : OP_STEP;
      acc_write = wr_req;
    end
  end

endmodule

// File: rtl/sbsr_burst_gen.sv
module sbsr_burst_gen
  import sbsr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  op_e               op,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic              linear,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              burst_act
);

  logic [ADDR_W-1:0]  base_q;
  logic [BURST_W-1:0] beat_q;
  logic [BURST_W-1:0] beat_inc;
  logic               act_q;
  logic [ADDR_W-1:0]  step_addr;

  assign beat_inc  = beat_q + 1'b1;
  assign cur_addr  = {base_q[ADDR_W-1:BURST_W],
                      burst_offset(base_q[BURST_W-1:0], beat_q, linear)};
  assign step_addr = {base_q[ADDR_W-1:BURST_W],
                      burst_offset(base_q[BURST_W-1:0], beat_inc, linear)};
  assign burst_act = act_q;

  always_comb begin
    case (op)
      OP_START: acc_addr = ext_addr;
      OP_STEP:  acc_addr = step_addr;
      default:  acc_addr = cur_addr;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      beat_q <= '0;
      act_q  <= 1'b0;
    end else begin
      case (op)
        OP_START: begin
          base_q <= ext_addr;
          beat_q <= '0;
          act_q  <= 1'b1;
        end
        OP_STEP:  beat_q <= beat_inc;
        OP_DESEL: act_q  <= 1'b0;
        default:  ;
      endcase
    end
  end

endmodule

// File: rtl/sbsr_lane_array.sv
module sbsr_lane_array #(
  parameter int ADDR_W = 8,
  parameter int LANE_W = 8,
  parameter int LANES  = 4
) (
  input  logic                    clk,
  input  logic                    wr_en,
  input  logic [LANES-1:0]        lane_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [LANE_W*LANES-1:0] wdata,
  input  logic                    rd_load,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [LANE_W*LANES-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];
    logic [LANE_W-1:0] out_q;

    always_ff @(posedge clk) begin
      if (wr_en && lane_en[g]) cells[wr_addr] <= wdata[g*LANE_W +: LANE_W];
      if (rd_load) out_q <= cells[rd_addr];
    end

    assign rdata[g*LANE_W +: LANE_W] = out_q;
  end

endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import sbsr_pkg::*;
#(
  parameter int  ADDR_W = 8,
  parameter int  LANE_W = 8,
  localparam int DATA_W = LANE_W * NUM_LANES
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 ce_n,
  input  logic                 ce2,
  input  logic                 ce2_n,
  input  logic                 sp_n,
  input  logic                 sc_n,
  input  logic                 adv_n,
  input  logic                 gw_n,
  input  logic                 bwe_n,
  input  logic [NUM_LANES-1:0] bw_n,
  input  logic                 linear_mode,
  input  logic                 oe_n,
  input  logic                 sleep,
  input  logic [DATA_W-1:0]    din,
  output logic [DATA_W-1:0]    dout,
  output logic                 dout_en
);

  op_e                  op;
  logic                 acc_write;
  logic                 burst_act;
  logic [ADDR_W-1:0]    acc_addr;
  logic [ADDR_W-1:0]    cur_addr;
  logic [NUM_LANES-1:0] lane_en;

  // named events, also watched by the checker
  logic access_fire;
  logic wr_fire;
  logic rd_fire;
  logic desel_fire;
  logic hold_fire;
  logic adv_fire;

  // output pipeline state
  logic              rd_pend_q;
  logic [ADDR_W-1:0] rd_addr_q;
  logic              vld_q;
  logic              wrflag_q;

  sbsr_decode u_decode (
    .ce_n      (ce_n),
    .ce2       (ce2),
    .ce2_n     (ce2_n),
    .sp_n      (sp_n),
    .sc_n      (sc_n),
    .adv_n     (adv_n),
    .gw_n      (gw_n),
    .bwe_n     (bwe_n),
    .bw_n      (bw_n),
    .burst_act (burst_act),
    .sleep     (sleep),
    .op        (op),
    .acc_write (acc_write)
  );

  sbsr_burst_gen #(.ADDR_W(ADDR_W)) u_burst (
    .clk       (clk),
    .rst_n     (rst_n),
    .op        (op),
    .ext_addr  (addr),
    .linear    (linear_mode),
    .acc_addr  (acc_addr),
    .cur_addr  (cur_addr),
    .burst_act (burst_act)
  );

  assign access_fire = (op == OP_START) || (op == OP_STEP) || (op == OP_WAIT);
  assign wr_fire     = access_fire && acc_write;
  assign rd_fire     = access_fire && !acc_write;
  assign desel_fire  = (op == OP_DESEL);
  assign hold_fire   = (op == OP_WAIT);
  assign adv_fire    = (op == OP_STEP);
  assign lane_en     = lane_enables(gw_n, bwe_n, bw_n);

  sbsr_lane_array #(
    .ADDR_W (ADDR_W),
    .LANE_W (LANE_W),
    .LANES  (NUM_LANES)
  ) u_array (
    .clk     (clk),
    .wr_en   (wr_fire),
    .lane_en (lane_en),
    .wr_addr (acc_addr),
    .wdata   (din),
    .rd_load (!sleep),
    .rd_addr (rd_addr_q),
    .rdata   (dout)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_pend_q <= 1'b0;
      rd_addr_q <= '0;
      vld_q     <= 1'b0;
      wrflag_q  <= 1'b0;
    end else if (!sleep) begin
      rd_pend_q <= rd_fire;
      rd_addr_q <= acc_addr;
      vld_q     <= rd_pend_q;
      wrflag_q  <= wr_fire;
    end
  end

  assign dout_en = vld_q && !oe_n && !sleep && !wrflag_q;

endmodule

// File: rtl/sbsr_checker.sv
module sbsr_checker #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sleep,
  input logic              oe_n,
  input logic              dout_en,
  input logic              wr_fire,
  input logic              desel_fire,
  input logic              hold_fire,
  input logic              adv_fire,
  input logic [ADDR_W-1:0] cur_addr
);

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !dout_en); // R1

  AST_ADV_KEEPS_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    adv_fire |=> cur_addr[ADDR_W-1:2] == $past(cur_addr[ADDR_W-1:2])); // R5

  AST_WAIT_HOLDS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    hold_fire |=> $stable(cur_addr)); // R6

  AST_DESEL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    desel_fire |=> ##1 (!dout_en || $past(sleep))); // R8

  AST_OE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dout_en); // R9

  AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> !dout_en); // R10

  AST_SLEEP_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !dout_en); // R11

  AST_SLEEP_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> $stable(cur_addr)); // R11

endmodule

bind burst_sram sbsr_checker #(.ADDR_W(ADDR_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .sleep      (sleep),
  .oe_n       (oe_n),
  .dout_en    (dout_en),
  .wr_fire    (wr_fire),
  .desel_fire (desel_fire),
  .hold_fire  (hold_fire),
  .adv_fire   (adv_fire),
  .cur_addr   (cur_addr)
);

// File: tb/burst_sram_tb_top.sv
`timescale 1ns/1ps
module burst_sram_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr;
  logic        ce_n, ce2, ce2_n, sp_n, sc_n, adv_n, gw_n, bwe_n;
  logic [3:0]  bw_n;
  logic        linear_mode, oe_n, sleep;
  logic [31:0] din;
  logic [31:0] dout;
  logic        dout_en;

  burst_sram dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .ce2(ce2), .ce2_n(ce2_n),
    .sp_n(sp_n), .sc_n(sc_n), .adv_n(adv_n), .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n),
    .linear_mode(linear_mode), .oe_n(oe_n), .sleep(sleep), .din(din),
    .dout(dout), .dout_en(dout_en)
  );

  always #5 clk = ~clk;

  int    checks = 0;
  int    fails  = 0;
  bit    ended  = 0;
  string cur_tag = "R1";

  // bench model state
  bit [31:0] m_mem [256];
  bit        m_act, m_rdpend, m_vld, m_wr;
  bit [7:0]  m_base, m_rdaddr;
  bit [1:0]  m_beat;
  bit [31:0] m_data;

  function automatic bit [1:0] beat_low(input bit [1:0] s, input bit [1:0] k, input bit lin);
    int sum;
    if (!lin) return s ^ k;
    sum = (int'(s) + int'(k)) % 4;
    return sum[1:0];
  endfunction

  task automatic chk_bit(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s dout_en got %b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic chk_word(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s dout got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic model_edge();
    bit sel, wr, acc;
    int op; // 0 none, 1 deselect, 2 start, 3 step, 4 wait
    bit [7:0] a;
    bit n_vld;
    bit [31:0] n_data;
    if (sleep) return;
    sel = !ce_n && ce2 && !ce2_n;
    wr  = !gw_n || (!bwe_n && bw_n != 4'hF);
    if (!sp_n && !ce_n) begin op = sel ? 2 : 1; wr = 0; end
    else if (!sc_n) op = sel ? 2 : 1;
    else if (m_act) op = adv_n ? 4 : 3;
    else op = 0;
    n_vld  = m_rdpend;
    n_data = m_mem[m_rdaddr];
    case (op)
      1: m_act = 0;
      2: begin m_base = addr; m_beat = 0; m_act = 1; end
      3: m_beat = m_beat + 2'd1;
      default: ;
    endcase
    acc = (op >= 2);
    a = {m_base[7:2], beat_low(m_base[1:0], m_beat, linear_mode)};
    if (acc && wr) begin
      for (int i = 0; i < 4; i++)
        if (!gw_n || (!bwe_n && !bw_n[i])) m_mem[a][i*8 +: 8] = din[i*8 +: 8];
    end
    m_rdpend = acc && !wr;
    m_rdaddr = a;
    m_wr     = acc && wr;
    m_vld    = n_vld;
    m_data   = n_data;
  endtask

  task automatic observe();
    bit exp_en;
    exp_en = m_vld && !oe_n && !sleep && !m_wr;
    chk_bit(cur_tag, dout_en, exp_en);
    if (exp_en) chk_word(cur_tag, dout, m_data);
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    observe();
  endtask

  task automatic idle();
    ce_n = 0; ce2 = 1; ce2_n = 0; sp_n = 1; sc_n = 1; adv_n = 1;
    gw_n = 1; bwe_n = 1; bw_n = 4'hF; oe_n = 0; sleep = 0; din = 32'h0;
  endtask

  task automatic sc_read(input bit [7:0] a);
    idle(); sc_n = 0; addr = a; step();
  endtask

  task automatic sc_write(input bit [7:0] a, input bit [31:0] d);
    idle(); sc_n = 0; addr = a; gw_n = 0; din = d; step();
  endtask

  task automatic drain(input int n);
    for (int i = 0; i < n; i++) begin idle(); step(); end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired at %0t", $time);
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    idle(); addr = 0; linear_mode = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R1: quiet after reset, strobe-free edges do nothing
    chk_bit("R1", dout_en, 1'b0);
    cur_tag = "R1";
    drain(2);

    // R3: fill every word with controller-strobe writes
    cur_tag = "R3";
    for (int a = 0; a < 256; a++) sc_write(a[7:0], (a * 32'h9E3779B1) ^ 32'h5A5A0000);
    sc_read(8'd5); drain(2);
    idle(); sc_n = 0; addr = 8'd6; bwe_n = 0; bw_n = 4'hF; din = 32'hDEADBEEF; step(); // no lane: read
    drain(2);

    // R2: processor start reads despite write controls
    cur_tag = "R2";
    idle(); sp_n = 0; addr = 8'd9; gw_n = 0; din = 32'h11111111; step();
    drain(2);
    sc_read(8'd9); drain(2);

    // R4: byte lanes
    cur_tag = "R4";
    idle(); sc_n = 0; addr = 8'd12; bwe_n = 0; bw_n = 4'b1010; din = 32'hAABBCCDD; step();
    sc_read(8'd12); drain(2);
    idle(); sc_n = 0; addr = 8'd13; gw_n = 0; bwe_n = 1; bw_n = 4'hF; din = 32'h01020304; step();
    idle(); sc_n = 0; addr = 8'd13; bwe_n = 0; bw_n = 4'b0111; din = 32'hFF000000; step();
    sc_read(8'd13); drain(2);

    // R5: advancing in both orders, with wrap
    cur_tag = "R5";
    for (int lm = 1; lm >= 0; lm--) begin
      linear_mode = lm[0];
      sc_read(8'h31);
      for (int i = 0; i < 5; i++) begin idle(); adv_n = 0; step(); end
      idle(); sc_n = 0; ce_n = 1; step(); // deselect
      drain(2);
    end
    linear_mode = 1;

    // R6: wait cycle write after processor start; repeated reads
    cur_tag = "R6";
    idle(); sp_n = 0; addr = 8'd20; step();
    idle(); gw_n = 0; din = 32'hCAFEF00D; step();
    sc_read(8'd20); drain(2);
    sc_read(8'd21);
    for (int i = 0; i < 3; i++) begin idle(); step(); end

    // R7: processor strobe ignored while ce_n high; expansion deselects
    cur_tag = "R7";
    sc_read(8'd40);
    idle(); sp_n = 0; ce_n = 1; addr = 8'd99; adv_n = 0; step();
    idle(); adv_n = 0; step();
    drain(1);
    idle(); sc_n = 0; ce2 = 0; addr = 8'd77; step();
    drain(2);
    sc_read(8'd41);
    idle(); sp_n = 0; ce2_n = 1; addr = 8'd88; step();
    drain(2);

    // R8: two-cycle deselect
    cur_tag = "R8";
    sc_read(8'd50);
    idle(); sc_n = 0; ce_n = 1; step();
    idle(); adv_n = 0; step();
    idle(); adv_n = 0; step();

    // R9: output enable
    cur_tag = "R9";
    sc_read(8'd55);
    idle(); oe_n = 1; step();
    idle(); oe_n = 0; step();
    idle(); oe_n = 1; #1;
    chk_bit("R9", dout_en, 1'b0);
    drain(1);

    // R10: read then write of the same word, then read-back
    cur_tag = "R10";
    sc_read(8'd60);
    sc_write(8'd60, 32'h600D600D);
    drain(1);
    sc_read(8'd60); drain(2);

    // R11: sleep freezes everything
    cur_tag = "R11";
    sc_read(8'd70);
    idle(); sleep = 1; sc_n = 0; addr = 8'd3; gw_n = 0; din = 32'hBAD0BAD0; step();
    idle(); sleep = 1; adv_n = 0; step();
    idle(); adv_n = 0; step();
    drain(2);
    sc_read(8'd3); drain(2);

    // mixed constrained-random traffic
    cur_tag = "R5";
    for (int n = 0; n < 3000; n++) begin
      if (n == 1500) begin
        idle(); sc_n = 0; ce_n = 1; step();
        linear_mode = 0;
      end
      sleep = ($urandom % 20) == 0;
      oe_n  = ($urandom % 8) == 0;
      ce_n  = ($urandom % 10) == 0;
      ce2   = ($urandom % 16) != 0;
      ce2_n = ($urandom % 16) == 0;
      sp_n  = ($urandom % 6) != 0;
      sc_n  = ($urandom % 6) != 0;
      adv_n = 1'($urandom % 2);
      gw_n  = ($urandom % 6) != 0;
      bwe_n = ($urandom % 3) != 0;
      bw_n  = 4'($urandom);
      addr  = 8'($urandom);
      din   = $urandom;
      step();
    end
    drain(3);
    finish_run();
  end

endmodule